// File: doc/BRIEF.md
# Wrap-Tracking Cycle Counter

This block is a free-running cycle counter with a read port. Each read returns the count value and a two-bit wrap history. The history lets software build a longer time base out of a 32-bit counter without holding a 64-bit register in hardware. The counter advances by one on every clock. A small tracker records wraps from all-ones to zero. It has two bits:

- a parity bit (C), which toggles on each wrap;
- a sticky bit (Z), which is set when a wrap arrives while C is already set.

A read strobe returns the count and both bits, and clears the tracker. Each read therefore describes only the interval since the previous read.

Software reads the pair as ZC:

- 00: the count has not wrapped since the last read.
- 01: exactly one wrap occurred. Software can extend the count safely by adding one to its upper word.
- 10 or 11: at least two wraps occurred. The elapsed time can no longer be resolved.

The response leaves the block as a one-cycle valid pulse with the captured data. The port has no ready signal and no back-pressure. A response is produced for every strobe, one cycle after the strobe is sampled. It must be consumed in that cycle, because the data registers hold their value only until the next strobe.

Top module: `wrap_tracked_counter`

## Requirements
- R1: The count advances by exactly one on every rising clock edge outside reset, and wraps from all-ones to zero.
- R2: A read strobe sampled high at a rising edge makes `rsp_valid_o` high for the following cycle. In that cycle, `rsp_count_o` holds the count that was present at the sampling edge. When no strobe is sampled, `rsp_valid_o` is low in the following cycle.
- R3: The C tracking bit toggles on each wrap that is not coincident with a read.
- R4: The Z tracking bit is set by a wrap that occurs while C is set. Once set, Z stays set until the next read.
- R5: A read returns the tracking bits on `rsp_z_o` and `rsp_c_o` and clears them. ZC = 00 means no wrap since the previous read, and ZC = 01 means exactly one wrap.
- R6: After two or more wraps since the previous read, `rsp_z_o` = 1 and `rsp_c_o` equals the parity of the wrap count. Two wraps give 10, three give 11, and four give 10.
- R7: A wrap on the same edge as a read is not lost. It counts toward the next interval, so the tracker holds ZC = 01 after that edge.
- R8: Reset (synchronous, active high) clears the count, both tracking bits, `rsp_valid_o` and the response registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rd_i | input | 1 | Read strobe, sampled on the rising edge |
| rsp_valid_o | output | 1 | One-cycle pulse marking a read response |
| rsp_count_o | output | CNT_W | Count value captured at the read edge |
| rsp_c_o | output | 1 | Wrap parity bit returned by the read |
| rsp_z_o | output | 1 | Multiple-wrap sticky bit returned by the read |

## Verification
The hardest case to reach from the ports is a wrap that lands on the exact edge where a read is sampled. Both the capture and the clear then compete with the wrap increment. The bench builds the counter with a narrow width so that wraps take a few hundred cycles. It tracks the expected count from the first read after reset. From that expected count it computes an idle gap that puts the next strobe on the all-ones value. An immediate second read must then report a single wrap. The bench uses the same count arithmetic to place deliberate gaps of one to four wraps, which covers each ZC code.

// File: rtl/wrap_tracked_counter_pkg.sv
package wrap_tracked_counter_pkg;

  // Overflow history returned with every read
  typedef struct packed {
    logic z;  // two or more wraps since last read
    logic c;  // parity of wraps since last read
  } wrap_hist_t;

  localparam wrap_hist_t HIST_CLEAR = '{z: 1'b0, c: 1'b0};

endpackage

// File: rtl/wtc_count_core.sv
module wtc_count_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_q + CNT_ONE;
  end

  // wrap happens on the edge leaving the all-ones value
  assign wrap_o = (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;

  // R1
  count_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (cnt_q == ($past(cnt_q) + CNT_ONE)));

endmodule

// File: rtl/wtc_wrap_tracker.sv
module wtc_wrap_tracker
  import wrap_tracked_counter_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       wrap_i,
  input  logic       clear_i,
  output wrap_hist_t hist_o
);

  logic c_q, z_q;
  logic c_d, z_d;

  always_comb begin
    c_d = c_q;
    z_d = z_q;
    if (clear_i) begin
      // a coincident wrap opens the next interval with one wrap already seen
      c_d = wrap_i;
      z_d = 1'b0;
    end else if (wrap_i) begin
      c_d = ~c_q;
      z_d = z_q | c_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      c_q <= c_d;
      z_q <= z_d;
    end
  end

  assign hist_o = '{z: z_q, c: c_q};

  // R3
  c_toggle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wrap_i && !clear_i) |=> (c_q != $past(c_q)));
  // R3
  c_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!wrap_i && !clear_i) |=> $stable(c_q));
  // R4
  z_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (z_q && !clear_i) |=> z_q);
  // R4
  z_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wrap_i && c_q && !clear_i) |=> z_q);
  // R5
  clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (clear_i && !wrap_i) |=> (!c_q && !z_q));
  // R7
  wrap_on_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (clear_i && wrap_i) |=> (c_q && !z_q));

endmodule

// File: rtl/wtc_read_capture.sv
module wtc_read_capture
  import wrap_tracked_counter_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  wrap_hist_t       hist_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] cnt_o,
  output wrap_hist_t       hist_o
);

  logic             valid_q;
  logic [CNT_W-1:0] cnt_q;
  wrap_hist_t       hist_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
      hist_q  <= HIST_CLEAR;
    end else begin
      valid_q <= rd_i;
      if (rd_i) begin
        cnt_q  <= cnt_i;
        hist_q <= hist_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign cnt_o   = cnt_q;
  assign hist_o  = hist_q;

  // R2
  rsp_after_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_i |=> (valid_o && (cnt_o == $past(cnt_i)) && (hist_o == $past(hist_i))));
  // R2
  no_rsp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_i |=> !valid_o);

endmodule

// File: rtl/wrap_tracked_counter.sv
module wrap_tracked_counter
  import wrap_tracked_counter_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             rd_i,
  output logic             rsp_valid_o,
  output logic [CNT_W-1:0] rsp_count_o,
  output logic             rsp_c_o,
  output logic             rsp_z_o
);

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  wrap_hist_t       hist_live;
  wrap_hist_t       hist_rsp;

  wtc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  wtc_wrap_tracker u_track (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wrap_i  (wrap),
    .clear_i (rd_i),
    .hist_o  (hist_live)
  );

  wtc_read_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .rd_i    (rd_i),
    .cnt_i   (cnt),
    .hist_i  (hist_live),
    .valid_o (rsp_valid_o),
    .cnt_o   (rsp_count_o),
    .hist_o  (hist_rsp)
  );

  assign rsp_c_o = hist_rsp.c;
  assign rsp_z_o = hist_rsp.z;

  // R6
  multi_wrap_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_i && hist_live.z) |=> rsp_z_o);

endmodule

// File: tb/tb_wrap_tracked_counter.sv
module tb_wrap_tracked_counter;
  localparam int W   = 8;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rd  = 1'b0;
  logic         rsp_valid;
  logic [W-1:0] rsp_count;
  logic         rsp_c, rsp_z;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;   // expected count at the most recent read edge
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  wrap_tracked_counter #(.CNT_W(W)) dut (
    .clk_i(clk), .rst_i(rst), .rd_i(rd),
    .rsp_valid_o(rsp_valid), .rsp_count_o(rsp_count),
    .rsp_c_o(rsp_c), .rsp_z_o(rsp_z)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one read: strobe for one cycle, sample the response at the next negedge
  task automatic do_read(output int cnt, output int z, output int c, output int v);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    cnt = int'(rsp_count); z = int'(rsp_z); c = int'(rsp_c); v = int'(rsp_valid);
  endtask

  // idle n cycles, then read; compare with expectations from count arithmetic
  task automatic gap_read(input int n, input string tag);
    int cnt, z, c, v, d, w, e;
    repeat (n) begin
      @(negedge clk);
      chk({tag, " R2 no response while idle"}, int'(rsp_valid), 0);
    end
    d = n + 1;
    w = (exp_cnt + d) / MOD;
    e = (exp_cnt + d) % MOD;
    do_read(cnt, z, c, v);
    chk({tag, " R2 valid"}, v, 1);
    chk({tag, " R1 count"}, cnt, e);
    chk({tag, " R5/R6 z"}, z, (w >= 2) ? 1 : 0);
    chk({tag, " R3/R5/R6 c"}, c, w % 2);
    exp_cnt = e;
  endtask

  task automatic t_reset();
    int cnt, z, c, v;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 valid in reset", int'(rsp_valid), 0);
    chk("R8 count in reset", int'(rsp_count), 0);
    chk("R8 flags in reset", int'({rsp_z, rsp_c}), 0);
    rst = 1'b0;
    do_read(cnt, z, c, v);
    chk("R8 first read valid", v, 1);
    chk("R8 first read count", cnt, 0);
    chk("R8 first read flags", z * 2 + c, 0);
    exp_cnt = 0;
  endtask

  task automatic t_no_wrap();   gap_read(10, "no-wrap ZC00");  endtask
  task automatic t_one_wrap();  gap_read(300, "one wrap ZC01"); endtask
  task automatic t_cleared();   gap_read(0, "back-to-back read cleared"); endtask
  task automatic t_two_wraps(); gap_read(2 * MOD, "two wraps ZC10 R4"); endtask
  task automatic t_three();     gap_read(3 * MOD - 5, "three wraps ZC11"); endtask
  task automatic t_four();      gap_read(4 * MOD - 1, "four wraps ZC10"); endtask

  // R7: strobe sampled exactly on the all-ones count
  task automatic t_wrap_on_read();
    int n = (MOD - 1 - exp_cnt - 1 + MOD) % MOD;
    gap_read(n, "R7 read on all-ones");
    chk("R7 count is all-ones", exp_cnt, MOD - 1);
    gap_read(0, "R7 coincident wrap counted next");
    gap_read(0, "R7 then cleared");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_no_wrap();
    t_one_wrap();
    t_cleared();
    t_two_wraps();
    t_three();
    t_four();
    t_wrap_on_read();
    t_one_wrap();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule